// File: doc/BRIEF.md
# Ganged Output Pin Control

This block is a port-control slice that lets a group of eight general-purpose pins be tied together on the board and driven in parallel as one high-current output. A one-shot configuration register holds a global gang enable and seven per-pin select bits. While ganging is enabled, the master pin and every selected pin are forced to output. Each of them then copies the master pin's data, drive-strength and slew-rate bits in place of its own.

Every managed pin is also arbitrated among four owners, in fixed priority order: analog function, gang, digital peripheral, plain GPIO. The inputs are a register write strobe with data and the per-pin control vectors from the GPIO registers, the peripherals and the analog enables. The outputs are the resolved per-pin controls that go to the pad ring, plus the register read-back. All pin paths are combinational. Only the configuration register is clocked.

Pin index 0 is the master pin, which is bit 0 of port C. Indices 7, 6, 5 and 4 are port B bits 5, 4, 3 and 2. Indices 3, 2 and 1 are port C bits 3, 2 and 1. There are no streaming paths, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `gang_port_ctrl`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0x00, and it always shows the current register value without changing it.
- R2: The first cycle after reset with `cfg_wr_en` high loads `cfg_wr_data` into the register, and the new value is visible on `cfg_rd_data` after that clock edge.
- R3: Every write after the first one has no effect until the next reset.
- R4: Register bit 0 is the gang enable. While it is 1, pin 0 (the master) is forced to output regardless of `gpio_dir[0]`, and it drives `gpio_dat[0]`.
- R5: Register bit k (k = 1..7) selects pin k. While the enable is 1 and bit k is 1, pin k is forced to output.
- R6: Every ganged pin drives `gpio_dat[0]` on `pad_do`, `gpio_drv[0]` on `pad_drv` and `gpio_slew[0]` on `pad_slew`, ignoring its own bits.
- R7: While the enable bit is 0, the select bits have no effect and every pin uses its own controls.
- R8: Gang ownership overrides a digital peripheral that claims the same pin (`per_en` high).
- R9: An analog enable on a pin overrides everything else: `pad_oe`, `pad_do`, `pad_drv` and `pad_slew` of that pin are all 0.
- R10: A pin that is neither analog nor ganged and has `per_en` high takes `pad_oe` from `per_oe` and `pad_do` from `per_dat`. It keeps its own drive and slew bits. Otherwise the pin uses `gpio_dir`, `gpio_dat`, `gpio_drv` and `gpio_slew`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 8 | Write data: bit 0 is enable, bits 7:1 are selects |
| cfg_rd_data | output | 8 | Current register value |
| gpio_dir | input | 8 | Per-pin GPIO direction (1 = output) |
| gpio_dat | input | 8 | Per-pin GPIO data |
| gpio_drv | input | 8 | Per-pin drive-strength select |
| gpio_slew | input | 8 | Per-pin slew-rate select |
| per_en | input | 8 | Per-pin peripheral claim |
| per_oe | input | 8 | Peripheral output enable |
| per_dat | input | 8 | Peripheral data |
| ana_en | input | 8 | Per-pin analog function enable |
| pad_oe | output | 8 | Resolved output enable |
| pad_do | output | 8 | Resolved output data |
| pad_drv | output | 8 | Resolved drive strength |
| pad_slew | output | 8 | Resolved slew rate |

## Verification
Faults in the register show up on `cfg_rd_data` one clock after the write that exposes them. A one-shot latch that never sets lets a second write change the value. A latch that sets too early ignores the first write. Because the pin paths are combinational, a wrong ownership decision shows up on the pad outputs in the same cycle that the inputs change. A wrong decision means the wrong priority, a swapped select index, or a ganged pin that reads its own data instead of the master's. The bench therefore sweeps ownership patterns while holding the master's bits different from the other pins' bits.

// File: rtl/gang_pkg.sv
package gang_pkg;
  localparam int unsigned NPIN   = 8;
  localparam int unsigned MASTER = 0;

  typedef enum logic [1:0] {
    SRC_GPIO   = 2'd0,
    SRC_PERIPH = 2'd1,
    SRC_GANG   = 2'd2,
    SRC_ANALOG = 2'd3
  } pin_src_e;
endpackage

// File: rtl/gang_cfg_reg.sv
module gang_cfg_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cfg_q,
  output logic         locked
);
  // One-shot register: the first strobe after reset loads the value and closes the latch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      locked <= 1'b0;
    end else if (wr_en && !locked) begin
      cfg_q  <= wr_data;
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/gang_pin_mux.sv
module gang_pin_mux
  import gang_pkg::*;
(
  input  logic analog,
  input  logic ganged,
  input  logic p_en,
  input  logic p_oe,
  input  logic p_dat,
  input  logic g_dir,
  input  logic g_dat,
  input  logic g_drv,
  input  logic g_slew,
  input  logic m_dat,
  input  logic m_drv,
  input  logic m_slew,
  output logic oe,
  output logic dout,
  output logic drv,
  output logic slew
);
  pin_src_e src;

  // Fixed ownership order: analog, then gang, then peripheral, then GPIO.
  always_comb begin
    if (analog)      src = SRC_ANALOG;
    else if (ganged) src = SRC_GANG;
    else if (p_en)   src = SRC_PERIPH;
    else             src = SRC_GPIO;
  end

  always_comb begin
    unique case (src)
      SRC_ANALOG: {oe, dout, drv, slew} = 4'b0000;
      SRC_GANG:   {oe, dout, drv, slew} = {1'b1, m_dat, m_drv, m_slew};
      SRC_PERIPH: {oe, dout, drv, slew} = {p_oe, p_dat, g_drv, g_slew};
      default:    {oe, dout, drv, slew} = {g_dir, g_dat, g_drv, g_slew};
    endcase
  end
endmodule

// File: rtl/gang_port_ctrl.sv
module gang_port_ctrl
  import gang_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic [NPIN-1:0] cfg_wr_data,
  output logic [NPIN-1:0] cfg_rd_data,
  input  logic [NPIN-1:0] gpio_dir,
  input  logic [NPIN-1:0] gpio_dat,
  input  logic [NPIN-1:0] gpio_drv,
  input  logic [NPIN-1:0] gpio_slew,
  input  logic [NPIN-1:0] per_en,
  input  logic [NPIN-1:0] per_oe,
  input  logic [NPIN-1:0] per_dat,
  input  logic [NPIN-1:0] ana_en,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_do,
  output logic [NPIN-1:0] pad_drv,
  output logic [NPIN-1:0] pad_slew
);
  logic [NPIN-1:0] cfg_q;
  logic            cfg_locked;
  logic [NPIN-1:0] gang_mask;

  gang_cfg_reg #(.W(NPIN)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg_q   (cfg_q),
    .locked  (cfg_locked)
  );

  assign cfg_rd_data = cfg_q;

  // Bit 0 enables the gang and also makes the master pin a member; bits 7:1 pick the others.
  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      if (i == MASTER) gang_mask[i] = cfg_q[0];
      else             gang_mask[i] = cfg_q[0] & cfg_q[i];
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    gang_pin_mux u_mux (
      .analog (ana_en[p]),
      .ganged (gang_mask[p]),
      .p_en   (per_en[p]),
      .p_oe   (per_oe[p]),
      .p_dat  (per_dat[p]),
      .g_dir  (gpio_dir[p]),
      .g_dat  (gpio_dat[p]),
      .g_drv  (gpio_drv[p]),
      .g_slew (gpio_slew[p]),
      .m_dat  (gpio_dat[MASTER]),
      .m_drv  (gpio_drv[MASTER]),
      .m_slew (gpio_slew[MASTER]),
      .oe     (pad_oe[p]),
      .dout   (pad_do[p]),
      .drv    (pad_drv[p]),
      .slew   (pad_slew[p])
    );
  end
endmodule

// File: rtl/gang_port_ctrl_chk.sv
module gang_port_ctrl_chk #(
  parameter int unsigned NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr_en,
  input logic [NPIN-1:0] cfg_wr_data,
  input logic [NPIN-1:0] cfg_rd_data,
  input logic            cfg_locked,
  input logic [NPIN-1:0] gpio_dat,
  input logic [NPIN-1:0] gpio_drv,
  input logic [NPIN-1:0] gpio_slew,
  input logic [NPIN-1:0] ana_en,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_do,
  input logic [NPIN-1:0] pad_drv,
  input logic [NPIN-1:0] pad_slew
);
  logic [NPIN-1:0] members;
  assign members = cfg_rd_data[0] ? ({cfg_rd_data[NPIN-1:1], 1'b1} & ~ana_en) : '0;

  p_first_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !cfg_locked) |=> (cfg_rd_data == $past(cfg_wr_data)));

  p_write_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> $stable(cfg_rd_data));

  p_gang_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (members & ~pad_oe) == '0);

  p_gang_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (members & ((pad_do ^ {NPIN{gpio_dat[0]}}) | (pad_drv ^ {NPIN{gpio_drv[0]}})
                | (pad_slew ^ {NPIN{gpio_slew[0]}}))) == '0);

  p_analog_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ana_en & (pad_oe | pad_do | pad_drv | pad_slew)) == '0);
endmodule

bind gang_port_ctrl gang_port_ctrl_chk #(.NPIN(8)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .cfg_locked  (cfg_locked),
  .gpio_dat    (gpio_dat),
  .gpio_drv    (gpio_drv),
  .gpio_slew   (gpio_slew),
  .ana_en      (ana_en),
  .pad_oe      (pad_oe),
  .pad_do      (pad_do),
  .pad_drv     (pad_drv),
  .pad_slew    (pad_slew)
);

// File: tb/sim_gang_port_ctrl.sv
`timescale 1ns/1ps
module sim_gang_port_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic [7:0] cfg_rd_data;
  logic [7:0] gpio_dir = '0, gpio_dat = '0, gpio_drv = '0, gpio_slew = '0;
  logic [7:0] per_en = '0, per_oe = '0, per_dat = '0, ana_en = '0;
  logic [7:0] pad_oe, pad_do, pad_drv, pad_slew;

  always #2.5 clk = ~clk;

  gang_port_ctrl u0 (.*);

  typedef struct {
    string      tag;
    logic [7:0] oe, dout, drv, slew, rd;
  } item_t;

  item_t      sb[$];
  event       chk_ev;
  int         errors = 0;
  int         checks = 0;
  logic [7:0] m_cfg = '0;
  logic       m_locked = 1'b0;
  bit         done = 0;

  // Driver side: compute the expected pad controls from the requirements and queue them.
  task automatic push_check(input string tag);
    item_t it;
    it.tag = tag;
    it.rd  = m_cfg;
    for (int i = 0; i < 8; i++) begin
      logic g;
      g = m_cfg[0] && (i == 0 || m_cfg[i]);
      if (ana_en[i])      {it.oe[i], it.dout[i], it.drv[i], it.slew[i]} = 4'b0000;
      else if (g)         {it.oe[i], it.dout[i], it.drv[i], it.slew[i]} = {1'b1, gpio_dat[0], gpio_drv[0], gpio_slew[0]};
      else if (per_en[i]) {it.oe[i], it.dout[i], it.drv[i], it.slew[i]} = {per_oe[i], per_dat[i], gpio_drv[i], gpio_slew[i]};
      else                {it.oe[i], it.dout[i], it.drv[i], it.slew[i]} = {gpio_dir[i], gpio_dat[i], gpio_drv[i], gpio_slew[i]};
    end
    sb.push_back(it);
    ->chk_ev;
    #2;
  endtask

  // Monitor side: pop and compare once the combinational outputs have settled.
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (sb.size() > 0) begin
        item_t e;
        e = sb.pop_front();
        checks++;
        if (cfg_rd_data !== e.rd || pad_oe !== e.oe || pad_do !== e.dout ||
            pad_drv !== e.drv || pad_slew !== e.slew) begin
          errors++;
          $display("FAIL %s: got rd=%h oe=%h do=%h drv=%h slew=%h exp rd=%h oe=%h do=%h drv=%h slew=%h",
                   e.tag, cfg_rd_data, pad_oe, pad_do, pad_drv, pad_slew,
                   e.rd, e.oe, e.dout, e.drv, e.slew);
        end
      end
    end
  end

  task automatic pins(input logic [7:0] dir, dat, drv, slew, pe, po, pd, an);
    @(negedge clk);
    gpio_dir = dir; gpio_dat = dat; gpio_drv = drv; gpio_slew = slew;
    per_en = pe; per_oe = po; per_dat = pd; ana_en = an;
  endtask

  task automatic write_cfg(input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (!m_locked) begin m_cfg = d; m_locked = 1'b1; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_cfg = '0; m_locked = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    pins(8'h3C, 8'hA6, 8'h5A, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00);
    push_check("R1 reset value and plain GPIO");
    push_check("R1 read has no side effect");

    // Master bits (index 0) differ from the others, so copying is visible.
    pins(8'h00, 8'h01, 8'hFE, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
    write_cfg(8'hA5);
    push_check("R2 R4 R5 R6 first write enables gang");
    write_cfg(8'h5B);
    push_check("R3 second write ignored");
    write_cfg(8'h00);
    push_check("R3 third write ignored");
    pins(8'h00, 8'hFE, 8'h01, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00);
    push_check("R6 master zero copied to ganged pins");
    pins(8'h00, 8'h55, 8'h33, 8'h0F, 8'hFF, 8'h0F, 8'hF0, 8'h00);
    push_check("R8 R10 gang beats peripheral");
    pins(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h30, 8'h30, 8'h30, 8'h81);
    push_check("R9 analog beats gang and peripheral");
    pins(8'hFF, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01);
    push_check("R9 analog master released, members still copy");

    do_reset();
    pins(8'h0F, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
    push_check("R1 value cleared by reset");
    write_cfg(8'hFE);
    push_check("R7 selects without enable have no effect");
    pins(8'h00, 8'hFF, 8'h0F, 8'hF0, 8'hAA, 8'h0A, 8'hA0, 8'h00);
    push_check("R10 peripheral owns without gang");
    write_cfg(8'hFF);
    push_check("R3 write ignored after reset-first write");

    do_reset();
    write_cfg(8'h03);
    pins(8'h00, 8'h01, 8'h01, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00);
    push_check("R5 R8 single select bit 1 with peripheral claim");
    pins(8'hFE, 8'hFE, 8'hFE, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00);
    push_check("R4 master forced output despite direction 0");

    @(negedge clk);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule